// File: doc/BRIEF.md
# Radio Byte FIFO with Serial Bridge

This block buffers payload bytes between a host microcontroller and the bit-serial modem datapath of a packet radio. A byte-wide FIFO, whose usable depth is picked at run time, sits between two ports. On the host side, a SPI-style data port moves exactly one byte per chip-select low period. On the modem side, an 8-bit shift register serialises bytes for the modulator in transmit and assembles demodulated bits into bytes in receive, pacing both directions with a strobe that is divided down from the system clock.

The operating mode picks the direction. In transmit mode, host frames are writes and the serialiser drains the FIFO. In receive mode, the deserialiser fills the FIFO and host frames are reads. In sleep mode the serial side is frozen and the host can still drain whatever was received. The host chip select, clock and data pins are brought into the system clock through two-stage synchronisers. Empty, full and fill-level flags, along with sticky error flags, report the buffer state.

Top module: `radio_byte_buffer`

## Requirements
- R1: Bytes leave the FIFO in the same order they entered it, whichever port pushed or popped them.
- R2: `depth_sel` selects capacity 00=16, 01=32, 10=48, 11=64 bytes. `fifo_full` is high when the FIFO holds that many bytes, and `fifo_empty` is high when it holds none. The two are never high together.
- R3: Mode encoding: 00 sleep, 01 transmit, 10 receive, 11 sleep. In transmit, at each clock edge that ends a cycle with `bit_strobe` high, the next bit is driven on `mod_bit` with `mod_valid` high. Bytes go out MSB first over 8 strobes, and a new byte is popped at the strobe that follows the last bit. `mod_bit` changes only at such edges.
- R4: In receive, `demod_bit` is sampled at each edge that ends a cycle with `bit_strobe` high. The first sampled bit becomes the MSB, and every eighth sample pushes the completed byte. Entering the mode restarts the bit count.
- R5: `bit_strobe` is high for exactly one cycle out of every `rate_div`+1 cycles.
- R6: Outside transmit mode, a falling `spi_csn` pops one byte. `spi_miso` presents bits 7 down to 0, one per `spi_sck` period: each bit is stable before the rising edge and the next bit follows the falling edge. `spi_mosi` has no effect on a read.
- R7: Only one byte moves per chip-select low period. Further `spi_sck` cycles in the same low period pop and push nothing, and a new frame starts only after `spi_csn` has gone high.
- R8: In transmit mode, a host frame samples `spi_mosi` on 8 rising `spi_sck` edges, MSB first, and pushes the byte after the eighth. A frame that ends with fewer than 8 rising edges pushes nothing.
- R9: `spi_miso_oe` is low whenever `spi_csn` is high or the mode is transmit.
- R10: A host read of an empty FIFO returns 0x00 and sets the sticky `underflow` flag.
- R11: A push into a full FIFO is dropped, leaves the contents unchanged and sets the sticky `overflow` flag.
- R12: Any change of `depth_sel` empties the FIFO.
- R13: When the transmitter needs a byte after sending one and the FIFO is empty, `mod_bit` holds its last value, `mod_valid` drops and the sticky `tx_underrun` flag sets. An empty FIFO before the first byte after entering transmit mode does not set it.
- R14: `level_hit` is high while the fill count is at least `level_mark`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| depth_sel | input | 2 | FIFO capacity select |
| mode | input | 2 | Operating mode (sleep, transmit, receive) |
| rate_div | input | DIV_W | Bit period minus one, in clock cycles |
| level_mark | input | CW | Fill level for `level_hit` |
| spi_csn | input | 1 | Host data chip select, active low |
| spi_sck | input | 1 | Host serial clock |
| spi_mosi | input | 1 | Host serial data in |
| spi_miso | output | 1 | Host serial data out |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad |
| demod_bit | input | 1 | Serial bit from the demodulator |
| mod_bit | output | 1 | Serial bit to the modulator |
| mod_valid | output | 1 | `mod_bit` carries payload |
| bit_strobe | output | 1 | One-cycle bit-rate pulse |
| fifo_empty | output | 1 | FIFO holds no bytes |
| fifo_full | output | 1 | FIFO holds its selected capacity |
| level_hit | output | 1 | Fill count at or above `level_mark` |
| overflow | output | 1 | Sticky: a push was dropped |
| underflow | output | 1 | Sticky: a read hit an empty FIFO |
| tx_underrun | output | 1 | Sticky: transmitter starved after a byte |

## Verification
Host pins pass through two synchroniser stages and one edge-detect register. A chip-select fall therefore puts the popped byte on MISO about four clocks later, and a push lands in the fill flags a similar time after the eighth rising SCK edge. The bench holds every SCK half period for eight clocks, samples MISO just before each rising edge, and compares the flags with its queue model on every clock only in quiet windows that start after those delays. On the modem side, a result appears one clock after the cycle that carries `bit_strobe`. The bench drives receive bits so they are stable across that cycle and records transmitted bits on the falling edge after it.

// File: rtl/rbb_pkg.sv
package rbb_pkg;
    typedef enum logic [1:0] {
        MODE_SLEEP = 2'b00,
        MODE_TX    = 2'b01,
        MODE_RX    = 2'b10,
        MODE_IDLE2 = 2'b11
    } mode_e;

    localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/rbb_fifo.sv
module rbb_fifo
    import rbb_pkg::*;
#(
    parameter int unsigned STEP = 16,
    localparam int unsigned MAX_DEPTH = 4 * STEP,
    localparam int unsigned AW = $clog2(MAX_DEPTH),
    localparam int unsigned CW = $clog2(MAX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        depth_sel,
    input  logic              push,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              pop,
    output logic [BYTE_W-1:0] rdata,
    output logic              empty,
    output logic              full,
    output logic [CW-1:0]     count,
    output logic              overflow,
    output logic              underflow
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic [1:0]    sel;
        logic          ovf;
        logic          unf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [BYTE_W-1:0] mem_q [MAX_DEPTH];
    logic [CW-1:0] cap;
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        cap     = CW'((32'(st_q.sel) + 32'd1) * STEP);
        do_push = push && (st_q.cnt != cap);
        do_pop  = pop && (st_q.cnt != '0);
        if (push && !do_push) st_d.ovf = 1'b1;
        if (pop && !do_pop)   st_d.unf = 1'b1;
        if (do_push) st_d.wr = (st_q.wr == AW'(cap - 1'b1)) ? '0 : st_q.wr + 1'b1;
        if (do_pop)  st_d.rd = (st_q.rd == AW'(cap - 1'b1)) ? '0 : st_q.rd + 1'b1;
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        st_d.sel = depth_sel;
        if (depth_sel != st_q.sel) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= wdata;
    end

    assign rdata     = (st_q.cnt == '0) ? '0 : mem_q[st_q.rd];
    assign empty     = (st_q.cnt == '0);
    assign full      = (st_q.cnt == cap);
    assign count     = st_q.cnt;
    assign overflow  = st_q.ovf;
    assign underflow = st_q.unf;
endmodule

// File: rtl/rbb_host_port.sv
module rbb_host_port
    import rbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              write_mode,
    input  logic              spi_csn,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic [BYTE_W-1:0] fifo_rdata,
    output logic              pop,
    output logic              push,
    output logic [BYTE_W-1:0] wdata,
    output logic              spi_miso,
    output logic              spi_miso_oe
);
    typedef struct packed {
        logic [1:0]        csn_sy;
        logic              csn_prev;
        logic [1:0]        sck_sy;
        logic              sck_prev;
        logic [1:0]        mosi_sy;
        logic [BYTE_W-1:0] sh;
        logic [3:0]        bits;
        logic              active;
    } host_st_t;

    host_st_t st_d, st_q;
    logic csn_s, sck_s, mosi_s, csn_fall, sck_rise, sck_fall;

    always_comb begin
        st_d          = st_q;
        pop           = 1'b0;
        push          = 1'b0;
        csn_s         = st_q.csn_sy[1];
        sck_s         = st_q.sck_sy[1];
        mosi_s        = st_q.mosi_sy[1];
        csn_fall      = !csn_s && st_q.csn_prev;
        sck_rise      = sck_s && !st_q.sck_prev;
        sck_fall      = !sck_s && st_q.sck_prev;
        wdata         = {st_q.sh[BYTE_W-2:0], mosi_s};
        st_d.csn_sy   = {st_q.csn_sy[0], spi_csn};
        st_d.sck_sy   = {st_q.sck_sy[0], spi_sck};
        st_d.mosi_sy  = {st_q.mosi_sy[0], spi_mosi};
        st_d.csn_prev = csn_s;
        st_d.sck_prev = sck_s;

        if (csn_s) begin
            st_d.active = 1'b0;
            st_d.bits   = '0;
        end else if (csn_fall) begin
            st_d.active = 1'b1;
            st_d.bits   = '0;
            if (write_mode) begin
                st_d.sh = '0;
            end else begin
                pop     = 1'b1;
                st_d.sh = fifo_rdata;
            end
        end else if (st_q.active) begin
            if (sck_rise) begin
                st_d.bits = st_q.bits + 1'b1;
                if (write_mode) st_d.sh = wdata;
                if (st_q.bits == 4'd7) begin
                    st_d.active = 1'b0;
                    push        = write_mode;
                end
            end else if (sck_fall && !write_mode && st_q.bits != '0) begin
                st_d.sh = {st_q.sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.csn_sy   <= 2'b11;
            st_q.csn_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign spi_miso    = st_q.sh[BYTE_W-1];
    assign spi_miso_oe = !spi_csn && !write_mode;
endmodule

// File: rtl/rbb_serial.sv
module rbb_serial
    import rbb_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic [DIV_W-1:0]  rate_div,
    input  logic [BYTE_W-1:0] fifo_rdata,
    input  logic              fifo_empty,
    input  logic              demod_bit,
    output logic              pop,
    output logic              push,
    output logic [BYTE_W-1:0] wdata,
    output logic              mod_bit,
    output logic              mod_valid,
    output logic              bit_strobe,
    output logic              tx_underrun
);
    typedef struct packed {
        logic [DIV_W-1:0]  div;
        mode_e             mode_q;
        logic [BYTE_W-1:0] sh;
        logic [2:0]        bits;
        logic              mod;
        logic              valid;
        logic              unr;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d  = st_q;
        pop   = 1'b0;
        push  = 1'b0;
        tick  = (st_q.div >= rate_div);
        wdata = {st_q.sh[BYTE_W-2:0], demod_bit};
        st_d.div = tick ? '0 : st_q.div + 1'b1;

        if (mode != st_q.mode_q) begin
            st_d.mode_q = mode;
            st_d.bits   = '0;
            st_d.valid  = 1'b0;
        end else if (tick) begin
            if (mode == MODE_TX) begin
                if (st_q.bits == '0) begin
                    if (!fifo_empty) begin
                        pop        = 1'b1;
                        st_d.mod   = fifo_rdata[BYTE_W-1];
                        st_d.sh    = {fifo_rdata[BYTE_W-2:0], 1'b0};
                        st_d.bits  = 3'd7;
                        st_d.valid = 1'b1;
                    end else begin
                        if (st_q.valid) st_d.unr = 1'b1;
                        st_d.valid = 1'b0;
                    end
                end else begin
                    st_d.mod  = st_q.sh[BYTE_W-1];
                    st_d.sh   = {st_q.sh[BYTE_W-2:0], 1'b0};
                    st_d.bits = st_q.bits - 1'b1;
                end
            end else if (mode == MODE_RX) begin
                st_d.sh   = wdata;
                st_d.bits = st_q.bits + 1'b1;
                push      = (st_q.bits == 3'd7);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.mode_q <= MODE_SLEEP;
        end else begin
            st_q <= st_d;
        end
    end

    assign mod_bit     = st_q.mod;
    assign mod_valid   = st_q.valid;
    assign bit_strobe  = tick;
    assign tx_underrun = st_q.unr;
endmodule

// File: rtl/radio_byte_buffer.sv
module radio_byte_buffer
    import rbb_pkg::*;
#(
    parameter int unsigned STEP = 16,
    parameter int unsigned DIV_W = 16,
    localparam int unsigned CW = $clog2(4 * STEP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       depth_sel,
    input  logic [1:0]       mode,
    input  logic [DIV_W-1:0] rate_div,
    input  logic [CW-1:0]    level_mark,
    input  logic             spi_csn,
    input  logic             spi_sck,
    input  logic             spi_mosi,
    output logic             spi_miso,
    output logic             spi_miso_oe,
    input  logic             demod_bit,
    output logic             mod_bit,
    output logic             mod_valid,
    output logic             bit_strobe,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic             level_hit,
    output logic             overflow,
    output logic             underflow,
    output logic             tx_underrun
);
    mode_e             mode_sel;
    logic              host_pop, host_push, ser_pop, ser_push;
    logic [BYTE_W-1:0] host_wdata, ser_wdata, fifo_rdata, fifo_wdata;
    logic [CW-1:0]     fifo_cnt;

    assign mode_sel   = mode_e'(mode);
    assign fifo_wdata = ser_push ? ser_wdata : host_wdata;

    rbb_fifo #(.STEP(STEP)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .depth_sel (depth_sel),
        .push      (host_push | ser_push),
        .wdata     (fifo_wdata),
        .pop       (host_pop | ser_pop),
        .rdata     (fifo_rdata),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fifo_cnt),
        .overflow  (overflow),
        .underflow (underflow)
    );

    rbb_host_port i_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .write_mode  (mode_sel == MODE_TX),
        .spi_csn     (spi_csn),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .fifo_rdata  (fifo_rdata),
        .pop         (host_pop),
        .push        (host_push),
        .wdata       (host_wdata),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe)
    );

    rbb_serial #(.DIV_W(DIV_W)) i_serial (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_sel),
        .rate_div    (rate_div),
        .fifo_rdata  (fifo_rdata),
        .fifo_empty  (fifo_empty),
        .demod_bit   (demod_bit),
        .pop         (ser_pop),
        .push        (ser_push),
        .wdata       (ser_wdata),
        .mod_bit     (mod_bit),
        .mod_valid   (mod_valid),
        .bit_strobe  (bit_strobe),
        .tx_underrun (tx_underrun)
    );

    assign level_hit = (fifo_cnt >= level_mark);
endmodule

// File: rtl/rbb_checker.sv
module rbb_checker #(
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [DIV_W-1:0] rate_div,
    input logic             spi_csn,
    input logic             spi_miso_oe,
    input logic             bit_strobe,
    input logic             mod_bit,
    input logic             mod_valid,
    input logic             fifo_empty,
    input logic             fifo_full,
    input logic             overflow,
    input logic             underflow,
    input logic             tx_underrun,
    input logic             host_push,
    input logic             ser_push,
    input logic             host_pop,
    input logic             ser_pop
);
    // R9
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_csn || mode == 2'b01) |-> !spi_miso_oe);

    // R2
    empty_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R10
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R13
    unr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |=> tx_underrun);

    // R13
    unr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_underrun) |-> !mod_valid);

    // R13
    mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_valid |=> (mod_valid || $stable(mod_bit)));

    // R3
    mod_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_strobe |=> $stable(mod_bit));

    // R5
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && rate_div != '0) |=> !bit_strobe);

    // R7
    one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_push && ser_push) && !(host_pop && ser_pop));
endmodule

bind radio_byte_buffer rbb_checker #(.DIV_W(DIV_W)) i_rbb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .rate_div    (rate_div),
    .spi_csn     (spi_csn),
    .spi_miso_oe (spi_miso_oe),
    .bit_strobe  (bit_strobe),
    .mod_bit     (mod_bit),
    .mod_valid   (mod_valid),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full),
    .overflow    (overflow),
    .underflow   (underflow),
    .tx_underrun (tx_underrun),
    .host_push   (host_push),
    .ser_push    (ser_push),
    .host_pop    (host_pop),
    .ser_pop     (ser_pop)
);

// File: tb/test_radio_byte_buffer.sv
`timescale 1ns/1ps
module test_radio_byte_buffer;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] depth_sel = 2'b00;
    logic [1:0] mode = 2'b00;
    logic [15:0] rate_div = 16'd3;
    logic [6:0] level_mark = 7'd3;
    logic spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, demod_bit = 1'b0;
    logic spi_miso, spi_miso_oe, mod_bit, mod_valid, bit_strobe;
    logic fifo_empty, fifo_full, level_hit, overflow, underflow, tx_underrun;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit cmp_en = 1'b0;
    bit col_en = 1'b0;
    bit strobe_seen = 1'b0;
    logic [7:0] model[$];
    logic txbits[$];

    always #2 clk = ~clk;

    radio_byte_buffer i_radio_byte_buffer (
        .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel), .mode(mode),
        .rate_div(rate_div), .level_mark(level_mark), .spi_csn(spi_csn),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe), .demod_bit(demod_bit), .mod_bit(mod_bit),
        .mod_valid(mod_valid), .bit_strobe(bit_strobe), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .level_hit(level_hit), .overflow(overflow),
        .underflow(underflow), .tx_underrun(tx_underrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int cap_now();
        return (int'(depth_sel) + 1) * 16;
    endfunction

    // quiet-window flag model, compared on every clock while enabled
    always @(negedge clk) begin
        if (cmp_en) begin
            check(fifo_empty == (model.size() == 0), "R2 empty", fifo_empty, model.size() == 0);
            check(fifo_full == (model.size() == cap_now()), "R2 full", fifo_full, model.size() == cap_now());
            check(level_hit == (model.size() >= int'(level_mark)), "R14 level", level_hit, model.size() >= int'(level_mark));
        end
        if (col_en && strobe_seen && mod_valid) txbits.push_back(mod_bit);
        strobe_seen = bit_strobe;
    end

    task automatic idle(input int n);
        cmp_en = 1'b1;
        repeat (n) @(negedge clk);
        cmp_en = 1'b0;
    endtask

    task automatic spi_frame(input logic [7:0] wb, input int nrise, input bit rd, output logic [7:0] rb);
        rb = 8'h00;
        spi_csn = 1'b0;
        for (int i = 0; i < nrise; i++) begin
            spi_mosi = (i < 8) ? wb[7-i] : 1'(i);
            repeat (HALF) @(negedge clk);
            if (i < 8) rb[7-i] = spi_miso;
            if (rd) check(spi_miso_oe == 1'b1, "R6 oe during read", spi_miso_oe, 1);
            else    check(spi_miso_oe == 1'b0, "R9 oe in tx", spi_miso_oe, 0);
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic host_read(input int nrise, input string req);
        logic [7:0] rb, exp;
        spi_frame(8'($urandom), nrise, 1'b1, rb);
        exp = (model.size() == 0) ? 8'h00 : model.pop_front();
        check(rb == exp, req, rb, exp);
    endtask

    task automatic rx_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            demod_bit = b[i];
            do @(negedge clk); while (!bit_strobe);
            @(posedge clk);
            #1;
        end
        if (model.size() < cap_now()) model.push_back(b);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int n;
        logic [7:0] tx_bytes[3];
        logic [7:0] rb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // reset state
        check(fifo_empty && !fifo_full, "R2 reset flags", {fifo_empty, fifo_full}, 2'b10);
        check(!overflow && !underflow && !tx_underrun, "R10 R11 R13 reset sticky",
              {overflow, underflow, tx_underrun}, 0);
        check(!spi_miso_oe && !mod_valid, "R9 reset oe", spi_miso_oe, 0);
        // R5: strobe every rate_div+1 cycles
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (bit_strobe) n++;
        end
        check(n == 10, "R5 strobe rate", n, 10);

        // R4: receive, then R6/R7 reads
        mode = 2'b10;
        rx_byte(8'hA5); rx_byte(8'h3C); rx_byte(8'h0F); rx_byte(8'hF0);
        mode = 2'b00;
        repeat (8) @(negedge clk);
        idle(20);
        host_read(16, "R7 extra sck no second pop");
        host_read(8, "R4 R6 second byte");
        level_mark = 7'd2;
        idle(10);
        host_read(8, "R1 third byte");
        host_read(8, "R1 fourth byte");
        idle(10);
        // R10 underflow
        host_read(8, "R10 empty read returns 00");
        check(underflow == 1'b1, "R10 underflow sticky", underflow, 1);

        // R11 overflow at depth 16
        mode = 2'b10;
        for (int i = 0; i < 17; i++) rx_byte(8'(i * 37 + 5));
        mode = 2'b00;
        repeat (8) @(negedge clk);
        check(fifo_full == 1'b1, "R2 full at 16", fifo_full, 1);
        check(overflow == 1'b1, "R11 overflow sticky", overflow, 1);
        idle(10);
        for (int i = 0; i < 16; i++) host_read(8, "R11 R1 contents after drop");
        idle(10);

        // R12 flush on depth change
        mode = 2'b10;
        rx_byte(8'h11); rx_byte(8'h22);
        mode = 2'b00;
        repeat (8) @(negedge clk);
        check(fifo_empty == 1'b0, "R12 before flush", fifo_empty, 0);
        depth_sel = 2'b01;
        model.delete();
        repeat (4) @(negedge clk);
        check(fifo_empty == 1'b1, "R12 flushed", fifo_empty, 1);

        // R2 capacity 32
        mode = 2'b10;
        for (int i = 0; i < 32; i++) rx_byte(8'(i ^ 8'h5A));
        mode = 2'b00;
        repeat (8) @(negedge clk);
        check(fifo_full == 1'b1, "R2 full at 32", fifo_full, 1);
        idle(20);
        for (int i = 0; i < 32; i++) host_read(8, "R1 drain 32");
        idle(10);

        // R3 R8 R13 transmit
        depth_sel = 2'b00;
        model.delete();
        mode = 2'b01;
        col_en = 1'b1;
        repeat (40) @(negedge clk);
        check(tx_underrun == 1'b0, "R13 no underrun before first byte", tx_underrun, 0);
        check(mod_valid == 1'b0, "R13 idle not valid", mod_valid, 0);
        tx_bytes[0] = 8'h96; tx_bytes[1] = 8'h5A; tx_bytes[2] = 8'hC3;
        spi_frame(tx_bytes[0], 8, 1'b0, rb);
        spi_frame(8'hFF, 4, 1'b0, rb);
        spi_frame(tx_bytes[1], 8, 1'b0, rb);
        spi_frame(tx_bytes[2], 8, 1'b0, rb);
        repeat (100) @(negedge clk);
        col_en = 1'b0;
        check(txbits.size() == 24, "R8 R3 bit count", txbits.size(), 24);
        for (int i = 0; i < 24 && i < txbits.size(); i++)
            check(txbits[i] == tx_bytes[i/8][7 - (i % 8)], "R3 tx bit", txbits[i], tx_bytes[i/8][7 - (i % 8)]);
        check(tx_underrun == 1'b1, "R13 underrun sticky", tx_underrun, 1);
        check(mod_valid == 1'b0, "R13 valid low", mod_valid, 0);
        check(mod_bit == 1'b1, "R13 last bit held", mod_bit, 1);
        mode = 2'b00;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule